// File: doc/BRIEF.md
# Dual-Channel Serial Audio Receiver

This block receives serial audio on two data lines that share a single bit clock and a single word-select line. Each data line feeds its own receiver lane, and each lane ends in a 24-bit data register. A word begins at the first rising bit-clock edge where word select holds a different level from the one it held at the previous rising edge. Once the selected number of bits has been shifted in, the lane left-justifies the word, keeps its upper 24 bits, loads them into its data register and pulses a one-cycle valid strobe.

A small control register sets the mode. It holds an enable for each lane, a master/slave select, a two-bit word-length code and a shift-direction bit. In master mode the block divides the system clock to make the bit clock, and it toggles word select after every word-length count of bit clocks. In slave mode the block samples both framing signals from outside. All logic runs on the system clock. The external framing inputs are registered before edge detection.

Top module: `audio_rx_pair`

## Requirements
- R1: A lane whose enable bit is clear raises no valid strobe, and its data register reads 0 from the cycle after the enable clears.
- R2: When both enable bits are clear, the whole section is idle: `bclk_out` and `ws_out` stay low and all framing state is reset.
- R3: Synchronous `rst` and `sw_rst` both clear the enable bits and the master bit, so `ctl_rdata` reads 0 afterwards.
- R4: With master set (bit 3), `clk_drive_en` is 1, `bclk_out` has a period of 2*CLK_DIV system clocks, and `ws_out` toggles once every N rising bit-clock edges, where N is the selected word length.
- R5: With master clear, `clk_drive_en` is 0 and the framing comes from `bclk_in` and `ws_in`. Data is sampled on the rising edges of `bclk_in`.
- R6: The word-length code in bits 5:4 selects 16 bits (00), 24 bits (01) or 32 bits (10). The code 11 acts as 24 bits. The strobe follows the Nth bit of a word.
- R7: A 16-bit word lands in bits 23:8 of the data register, with bits 7:0 cleared, in either shift direction.
- R8: From a 32-bit word, only the 24 most significant bits are kept. In MSB-first mode these are the first 24 bits received.
- R9: The direction bit (bit 6) selects MSB-first reception when it is 0 and LSB-first reception when it is 1.
- R10: Control readback places lane 0 enable at bit 0, lane 1 enable at bit 1, master at bit 3, word length at bits 5:4 and direction at bit 6. Bits 2 and 7 to 13 read 0.
- R11: Each completed word raises a valid strobe exactly one system-clock cycle long on every enabled lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous software reset of the control bits |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 14 | Control register write data |
| ctl_rdata | output | 14 | Control register readback |
| bclk_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sd_in | input | 2 | Serial data, one line per lane |
| bclk_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated word select (master mode) |
| clk_drive_en | output | 1 | High when the block drives the framing pins |
| rx_data0 | output | 24 | Lane 0 receive data register |
| rx_data1 | output | 24 | Lane 1 receive data register |
| rx_valid | output | 2 | One-cycle new-word strobe per lane |

## Verification
The vector table sends each word length in both shift directions. The two lanes carry different bit patterns at the same time, which shows whether the lanes are swapped, the bit order is reversed or a word is truncated at the wrong end. The 16-bit patterns have nonzero low bytes, so the bench can see whether the padding is cleared. The 32-bit patterns differ in their last byte from what a kept lower 24 bits would give. Directed cases cover the reserved length code, one lane disabled while the other runs, and master mode. In master mode a constant data line makes any mistake in the generated word length show up as a wrong bit pattern.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam int MAX_BITS = 32;
  localparam int DATA_W   = 24;
  localparam int CTL_W    = 14;
  localparam int LEN_W    = $clog2(MAX_BITS + 1);

  typedef struct packed {
    logic       dir;     // 1 = LSB-first
    logic [1:0] wl;      // word length code
    logic       master;
    logic [1:0] en;      // per-lane enables
  } ctl_t;

  function automatic logic [LEN_W-1:0] word_bits(input logic [1:0] wl);
    case (wl)
      2'b00:   word_bits = LEN_W'(16);
      2'b10:   word_bits = LEN_W'(32);
      default: word_bits = LEN_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/rx_ctl_reg.sv
module rx_ctl_reg
  import audio_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl,
  output logic [CTL_W-1:0] rdata
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[CTL_W-1:7], wdata[2]};

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      ctl <= '0;
    end else if (wr) begin
      ctl.en     <= wdata[1:0];
      ctl.master <= wdata[3];
      ctl.wl     <= wdata[5:4];
      ctl.dir    <= wdata[6];
    end
  end

  assign rdata = {{(CTL_W-7){1'b0}}, ctl.dir, ctl.wl, ctl.master, 1'b0, ctl.en};

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (ctl.en == 2'b00 && !ctl.master)); // R3
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import audio_rx_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on,
  input  logic             master,
  input  logic [1:0]       wl,
  input  logic             bclk_in,
  input  logic             ws_in,
  input  logic [1:0]       sd_in,
  output logic             bclk_out,
  output logic             ws_out,
  output logic             bit_evt,
  output logic             word_start,
  output logic [1:0]       sd_bit
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);

  logic [DIV_W-1:0] div_cnt;
  logic [LEN_W-1:0] gen_cnt, len;
  logic             m_rise, s_rise, ws_now, ws_prev, run_m;
  logic             b_s1, b_s2, w_s1;
  logic [1:0]       d_s1;

  assign len   = word_bits(wl);
  assign run_m = on && master;

  // master clock and framing generator
  always_ff @(posedge clk) begin
    if (rst || !run_m) begin
      div_cnt  <= '0;
      gen_cnt  <= '0;
      bclk_out <= 1'b0;
      ws_out   <= 1'b0;
    end else if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
      div_cnt  <= '0;
      bclk_out <= ~bclk_out;
      if (!bclk_out) begin
        if (gen_cnt == len - LEN_W'(1)) begin
          gen_cnt <= '0;
          ws_out  <= ~ws_out;
        end else begin
          gen_cnt <= gen_cnt + LEN_W'(1);
        end
      end
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  assign m_rise = run_m && (div_cnt == DIV_W'(CLK_DIV - 1)) && !bclk_out;

  // input registers for slave framing and data
  always_ff @(posedge clk) begin
    if (rst || !on) begin
      b_s1 <= 1'b0;
      b_s2 <= 1'b0;
      w_s1 <= 1'b0;
      d_s1 <= '0;
    end else begin
      b_s1 <= bclk_in;
      b_s2 <= b_s1;
      w_s1 <= ws_in;
      d_s1 <= sd_in;
    end
  end

  assign s_rise  = on && !master && b_s1 && !b_s2;
  assign bit_evt = master ? m_rise : s_rise;
  assign ws_now  = master ? ws_out : w_s1;
  assign sd_bit  = d_s1;

  always_ff @(posedge clk) begin
    if (rst || !on) ws_prev <= 1'b0;
    else if (bit_evt) ws_prev <= ws_now;
  end

  assign word_start = bit_evt && (ws_now != ws_prev);

  AST_IDLE_FRAMING: assert property (@(posedge clk) disable iff (rst)
    !run_m |=> (!bclk_out && !ws_out)); // R2
endmodule

// File: rtl/rx_lane.sv
module rx_lane
  import audio_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        wl,
  input  logic              dir,
  input  logic              bit_evt,
  input  logic              word_start,
  input  logic              sd,
  output logic [DATA_W-1:0] data,
  output logic              valid
);
  logic [MAX_BITS-1:0] sh, base, sh_nx, just;
  logic [LEN_W-1:0]    cnt, cnt_nx, len;
  logic                act, take, done;

  assign len    = word_bits(wl);
  assign take   = bit_evt && (word_start || act);
  assign base   = word_start ? '0 : sh;
  assign sh_nx  = dir ? {sd, base[MAX_BITS-1:1]} : {base[MAX_BITS-2:0], sd};
  assign cnt_nx = word_start ? LEN_W'(1) : cnt + LEN_W'(1);
  assign done   = take && (cnt_nx == len);
  // left-justify: LSB-first already fills from the top
  assign just   = dir ? sh_nx : (sh_nx << (LEN_W'(MAX_BITS) - len));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh    <= '0;
      cnt   <= '0;
      act   <= 1'b0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (take) begin
        sh  <= sh_nx;
        cnt <= cnt_nx;
        act <= !done;
        if (done) begin
          data  <= just[MAX_BITS-1 -: DATA_W];
          valid <= 1'b1;
        end
      end
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!valid && data == '0)); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R11
  AST_SHORT_PAD: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(wl) == 2'b00) |-> (data[7:0] == 8'h00)); // R7
endmodule

// File: rtl/audio_rx_pair.sv
module audio_rx_pair
  import audio_rx_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              bclk_in,
  input  logic              ws_in,
  input  logic [1:0]        sd_in,
  output logic              bclk_out,
  output logic              ws_out,
  output logic              clk_drive_en,
  output logic [DATA_W-1:0] rx_data0,
  output logic [DATA_W-1:0] rx_data1,
  output logic [1:0]        rx_valid
);
  localparam int LANES = 2;

  ctl_t                         ctl;
  logic                         on, bit_evt, word_start;
  logic [LANES-1:0]             sd_bit;
  logic [LANES-1:0][DATA_W-1:0] lane_data;

  rx_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .wr(ctl_wr),
    .wdata(ctl_wdata), .ctl(ctl), .rdata(ctl_rdata)
  );

  assign on           = |ctl.en;
  assign clk_drive_en = ctl.master;

  rx_framer #(.CLK_DIV(CLK_DIV)) u_framer (
    .clk(clk), .rst(rst), .on(on), .master(ctl.master), .wl(ctl.wl),
    .bclk_in(bclk_in), .ws_in(ws_in), .sd_in(sd_in),
    .bclk_out(bclk_out), .ws_out(ws_out),
    .bit_evt(bit_evt), .word_start(word_start), .sd_bit(sd_bit)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rx_lane u_lane (
      .clk(clk), .rst(rst), .en(ctl.en[i]), .wl(ctl.wl), .dir(ctl.dir),
      .bit_evt(bit_evt), .word_start(word_start), .sd(sd_bit[i]),
      .data(lane_data[i]), .valid(rx_valid[i])
    );
  end

  assign rx_data0 = lane_data[0];
  assign rx_data1 = lane_data[1];
endmodule

// File: tb/audio_rx_pair_test.sv
`timescale 1ns/1ps
module audio_rx_pair_test;
  localparam int DIV = 2;
  localparam int H   = 3;
  localparam logic [31:0] XMASK = 32'h5A5A_A5A5;
  // {wl, dir, word}
  localparam logic [34:0] VEC [6] = '{
    {2'b01, 1'b0, 32'h00AB_CDEF},
    {2'b01, 1'b1, 32'h0012_3456},
    {2'b00, 1'b0, 32'h0000_BEEF},
    {2'b00, 1'b1, 32'h0000_1234},
    {2'b10, 1'b0, 32'hDEAD_BEEF},
    {2'b10, 1'b1, 32'hCAFE_F00D}
  };

  logic        clk = 0, rst = 1, sw_rst = 0, ctl_wr = 0;
  logic [13:0] ctl_wdata = '0, ctl_rdata;
  logic        bclk_in = 0, ws_in = 0, bclk_out, ws_out, clk_drive_en;
  logic [1:0]  sd_in = '0, rx_valid;
  logic [23:0] rx_data0, rx_data1;
  int          checks = 0, fails = 0, vcnt0 = 0, vcnt1 = 0, cyc = 0;
  logic        ws_lvl = 0, done = 0;

  audio_rx_pair #(.CLK_DIV(DIV)) uut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst && rx_valid[0]) vcnt0++;
    if (!rst && rx_valid[1]) vcnt1++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: act=%0d exp<%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [13:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  function automatic int nbits(input logic [1:0] wl);
    return (wl == 2'b00) ? 16 : (wl == 2'b10) ? 32 : 24;
  endfunction

  function automatic logic [23:0] expect_of(input int n, input logic [31:0] w);
    if (n == 16) return {w[15:0], 8'h00};
    if (n == 32) return w[31:8];
    return w[23:0];
  endfunction

  task automatic send_word(input int n, input logic dir, input logic [31:0] w0, input logic [31:0] w1);
    ws_lvl = ~ws_lvl;
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = dir ? i : n - 1 - i;
      @(negedge clk);
      ws_in = ws_lvl; sd_in = {w1[idx], w0[idx]};
      repeat (H) @(negedge clk);
      bclk_in = 1;
      repeat (H) @(negedge clk);
      bclk_in = 0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk("R3 reset ctl", 32'(ctl_rdata), 0);
    chk("R5 reset drive", 32'(clk_drive_en), 0);
    chk("R2 reset bclk", 32'(bclk_out), 0);
    chk("R1 reset data0", 32'(rx_data0), 0);
    chk("R1 reset valid", 32'(rx_valid), 0);

    // control layout and software reset
    wr_ctl(14'h3FFF);
    chk("R10 readback", 32'(ctl_rdata), 32'h007B);
    @(negedge clk); sw_rst = 1; @(negedge clk); sw_rst = 0;
    chk("R3 sw_rst", 32'(ctl_rdata), 0);
    repeat (4) @(negedge clk);

    // vector table, slave mode, both lanes on
    foreach (VEC[k]) begin
      logic [1:0]  wl;
      logic        dr;
      logic [31:0] w;
      int          n, c0, c1;
      wl = VEC[k][34:33]; dr = VEC[k][32]; w = VEC[k][31:0];
      n = nbits(wl);
      wr_ctl({7'b0, dr, wl, 1'b0, 1'b0, 2'b11});
      c0 = vcnt0; c1 = vcnt1;
      send_word(n, dr, w, w ^ XMASK);
      chk($sformatf("R6 R7 R8 R9 vec%0d lane0", k), 32'(rx_data0), 32'(expect_of(n, w)));
      chk($sformatf("R6 R9 vec%0d lane1", k), 32'(rx_data1), 32'(expect_of(n, w ^ XMASK)));
      chk($sformatf("R11 vec%0d strobes", k), 32'((vcnt0 - c0) * 16 + (vcnt1 - c1)), 32'h11);
    end
    chk("R5 slave drive", 32'(clk_drive_en), 0);

    // reserved length code acts as 24 bits
    wr_ctl({7'b0, 1'b0, 2'b11, 1'b0, 1'b0, 2'b11});
    send_word(24, 1'b0, 32'h0013_579B, 32'h0024_68AC);
    chk("R6 code11 lane0", 32'(rx_data0), 32'h0013_579B);

    // lane 1 disabled
    begin
      int c1;
      c1 = vcnt1;
      wr_ctl({7'b0, 1'b0, 2'b01, 1'b0, 1'b0, 2'b01});
      send_word(24, 1'b0, 32'h0055_AA11, 32'h0077_EE22);
      chk("R1 lane1 data", 32'(rx_data1), 0);
      chk("R1 lane1 strobes", 32'(vcnt1 - c1), 0);
      chk("R1 lane0 runs", 32'(rx_data0), 32'h0055_AA11);
    end

    // master mode, 16-bit words
    begin
      int   t, rises, c0;
      logic pb, pw;
      sd_in = 2'b01;
      c0 = vcnt0;
      wr_ctl({7'b0, 1'b0, 2'b00, 1'b1, 1'b0, 2'b11});
      @(negedge clk);
      chk("R4 drive", 32'(clk_drive_en), 1);
      pw = ws_out;
      t = 0;
      while (ws_out == pw && t < 2000) begin @(negedge clk); t++; end
      pb = bclk_out; pw = ws_out; rises = 0; t = 0;
      while (t < 2000) begin
        @(negedge clk); t++;
        if (!pb && bclk_out) rises++;
        pb = bclk_out;
        if (ws_out != pw) break;
      end
      chk("R4 ws period", 32'(rises), 16);
      pb = bclk_out; t = 0;
      while (t < 100) begin @(negedge clk); t++; if (!pb && bclk_out) break; pb = bclk_out; end
      pb = bclk_out; t = 0;
      while (t < 100) begin @(negedge clk); t++; if (!pb && bclk_out) break; pb = bclk_out; end
      chk("R4 bclk period", 32'(t), 2 * DIV);
      chk("R11 master strobe", 32'(vcnt0 > c0), 1);
      chk("R7 master lane0", 32'(rx_data0), 32'hFFFF00);
      chk("R7 master lane1", 32'(rx_data1), 0);
    end

    // both disabled: section idle
    begin
      int seen;
      wr_ctl(14'h0008);
      seen = 0;
      repeat (40) begin @(negedge clk); if (bclk_out || ws_out) seen++; end
      chk("R2 idle framing", 32'(seen), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule